// File: doc/BRIEF.md
# Programmable Square-Wave Output Stage

This block turns a doubled 32.768 kHz reference into the square wave shown on an open-drain output pin. A small control register, written and read back through a plain byte port, decides whether the pin carries one of four square-wave rates or sits at a static level chosen by the host. The same divider that makes the wave also gives a one-cycle strobe once per second. A time-keeping counter uses that strobe to advance its seconds.

`clk_i` is expected to run at twice the reference rate, 65.536 kHz. The fastest output rate then comes from the lowest divider bit and keeps a 50% duty cycle. Every rate is a tap of one free-running binary divider, so all taps are low together at the moment the divider wraps. Control writes never reset or realign the divider. A change of rate takes effect at once, in whatever phase the new tap happens to be. The pin is modelled as an output-enable: when `pin_oe_o` is 1 the pad pulls low, and when it is 0 the pad is released and reads high.

Top module: `sqw_out`

## Requirements
- R1: After reset the control register reads 0x83 (static level 1, output disabled, rate code 11), `pin_oe_o` is 0 and `tick_o` is 0.
- R2: A write stores bit 7 (static level), bit 4 (enable) and bits 1:0 (rate code). Bits 6, 5, 3 and 2 always read 0. The new value is visible on `rd_data_o` in the cycle after the write edge.
- R3: With the enable at 0, the pin output shows the static level: `pin_oe_o` is 1 when the level bit is 0 and 0 when it is 1. It follows one cycle after the register changes and does not change while the register holds.
- R4: With the enable at 1 and rate code 11 (32.768 kHz), `pin_oe_o` toggles every clock cycle.
- R5: With the enable at 1 and rate code 10 (8.192 kHz), each half period lasts 4 clock cycles.
- R6: With the enable at 1 and rate code 01 (4.096 kHz), each half period lasts 8 clock cycles.
- R7: With the enable at 1 and rate code 00 (1 Hz), each half period lasts 32768 clock cycles.
- R8: `tick_o` is high for exactly one cycle once every 65536 cycles, whatever the control register holds.
- R9: While the output is enabled, the pin is driven low (`pin_oe_o` = 1) in every cycle in which `tick_o` is high. At 1 Hz this is the first low cycle after a high half, so the seconds strobe lines up with the falling edge of the wave.
- R10: Control writes do not disturb the divider. Changing the static level while the output is enabled leaves both the wave and the tick spacing unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Doubled reference clock (65.536 kHz) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register read-back |
| pin_oe_o | output | 1 | Open-drain pull-down enable (1 = pin low) |
| tick_o | output | 1 | One-cycle strobe at 1 Hz |

## Verification
A corrupted divider shows up first at 32.768 kHz: a missed toggle is visible within one cycle. At 1 Hz the same fault only appears as a tick spacing other than 65536 cycles, or as a tick that does not land on a low pin cycle. A wrong control state shows up on the read-back in the cycle after the write, and on the pin one cycle later: the pin holds the wrong static level, or its half-period length does not match the programmed rate. The tests measure each rate's half period twice. They also follow one full one-second period edge by edge, with a level-bit write made partway through it.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  typedef enum logic [1:0] {
    RATE_1HZ  = 2'b00,
    RATE_4K   = 2'b01,
    RATE_8K   = 2'b10,
    RATE_32K  = 2'b11
  } rate_e;

  typedef struct packed {
    logic  level;
    logic  en;
    rate_e rate;
  } ctrl_t;

  localparam int          CTRL_W     = 8;
  localparam int          LEVEL_POS  = 7;
  localparam int          EN_POS     = 4;
  localparam logic [7:0]  CTRL_RESET = 8'h83;

  // Divider bit feeding each rate; clock is twice the reference.
  function automatic int tap_of(rate_e r, int div_w);
    case (r)
      RATE_32K: return 0;
      RATE_8K:  return 2;
      RATE_4K:  return 3;
      default:  return div_w - 1;
    endcase
  endfunction

endpackage

// File: rtl/sqw_ctrl_reg.sv
module sqw_ctrl_reg
  import sqw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o,
  output logic [CTRL_W-1:0] rd_data_o
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.level <= CTRL_RESET[LEVEL_POS];
      ctrl_q.en    <= CTRL_RESET[EN_POS];
      ctrl_q.rate  <= rate_e'(CTRL_RESET[1:0]);
    end else if (wr_en_i) begin
      ctrl_q.level <= wr_data_i[LEVEL_POS];
      ctrl_q.en    <= wr_data_i[EN_POS];
      ctrl_q.rate  <= rate_e'(wr_data_i[1:0]);
    end
  end

  always_comb begin
    rd_data_o            = '0;
    rd_data_o[LEVEL_POS] = ctrl_q.level;
    rd_data_o[EN_POS]    = ctrl_q.en;
    rd_data_o[1:0]       = ctrl_q.rate;
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [DIV_W-1:0] cnt_nxt_o,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             tick_q;

  assign cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= (cnt_d == '0);  // wrap = falling edge of the top bit
    end
  end

  assign cnt_nxt_o = cnt_d;
  assign tick_o    = tick_q;

endmodule

// File: rtl/sqw_rate_mux.sv
module sqw_rate_mux
  import sqw_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic [DIV_W-1:0] cnt_i,
  input  ctrl_t            ctrl_i,
  output logic             wave_o
);

  localparam int N_RATES = 4;

  logic [N_RATES-1:0] taps;

  for (genvar g = 0; g < N_RATES; g++) begin : g_tap
    localparam int TAP = tap_of(rate_e'(g), DIV_W);
    assign taps[g] = cnt_i[TAP];
  end

  assign wave_o = ctrl_i.en ? taps[ctrl_i.rate] : ctrl_i.level;

endmodule

// File: rtl/sqw_out.sv
module sqw_out
  import sqw_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output logic              pin_oe_o,
  output logic              tick_o
);

  ctrl_t            ctrl;
  logic [DIV_W-1:0] cnt_nxt;
  logic             wave_d;
  logic             wave_q;

  sqw_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl),
    .rd_data_o (rd_data_o)
  );

  sqw_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_nxt_o (cnt_nxt),
    .tick_o    (tick_o)
  );

  sqw_rate_mux #(.DIV_W(DIV_W)) u_mux (
    .cnt_i  (cnt_nxt),
    .ctrl_i (ctrl),
    .wave_o (wave_d)
  );

  // Registered from the next count so wave and tick stay in phase.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= CTRL_RESET[LEVEL_POS];
    else         wave_q <= wave_d;
  end

  assign pin_oe_o = ~wave_q;

endmodule

// File: rtl/sqw_out_chk.sv
module sqw_out_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] rd_data_o,
  input logic       pin_oe_o,
  input logic       tick_o
);

  assert_rsv_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[6:5] == 2'b00) && (rd_data_o[3:2] == 2'b00));

  assert_static_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_data_o[4]) |-> (pin_oe_o == !$past(rd_data_o[7])));

  assert_fast_toggle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_data_o, 2) == 8'h13 && $past(rd_data_o) == 8'h13)
      |-> (pin_oe_o != $past(pin_oe_o)));

  assert_tick_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  assert_tick_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(rd_data_o[4])) |-> pin_oe_o);

endmodule

bind sqw_out sqw_out_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_data_o (rd_data_o),
  .pin_oe_o  (pin_oe_o),
  .tick_o    (tick_o)
);

// File: tb/tb_sqw_out.sv
`timescale 1ns/1ps
module tb_sqw_out;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       pin_oe_o;
  logic       tick_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  sqw_out dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .pin_oe_o  (pin_oe_o),
    .tick_o    (tick_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_data_i = v;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  // Measures two consecutive half periods of the pin.
  task automatic measure_half(input string req, input int exp);
    logic p;
    int   n;
    repeat (2) @(negedge clk_i);
    p = pin_oe_o;
    for (int i = 0; i < 200 && pin_oe_o == p; i++) @(negedge clk_i);
    for (int h = 0; h < 2; h++) begin
      p = pin_oe_o;
      n = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk_i);
        n++;
        if (pin_oe_o != p) break;
      end
      chk(req, n, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1 ctrl", rd_data_o, 8'h83);
    chk("R1 pin", pin_oe_o, 0);
    chk("R1 tick", tick_o, 0);
  endtask

  task automatic t_mask;
    write_ctrl(8'hFF);
    chk("R2 mask ff", rd_data_o, 8'h93);
    write_ctrl(8'h6C);
    chk("R2 mask 6c", rd_data_o, 8'h00);
  endtask

  task automatic t_static;
    int bad;
    write_ctrl(8'h03);
    @(negedge clk_i);
    chk("R3 level0", pin_oe_o, 1);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (pin_oe_o != 1'b1) bad++;
    end
    chk("R3 hold", bad, 0);
    write_ctrl(8'h82);
    @(negedge clk_i);
    chk("R3 level1", pin_oe_o, 0);
  endtask

  task automatic t_rates;
    write_ctrl(8'h13);
    measure_half("R4 32k half", 1);
    write_ctrl(8'h12);
    measure_half("R5 8k half", 4);
    write_ctrl(8'h11);
    measure_half("R6 4k half", 8);
  endtask

  task automatic t_one_hz;
    logic prev;
    int   c_fall, c_tick, extra;
    write_ctrl(8'h10);
    @(negedge clk_i);
    prev = pin_oe_o;
    for (int i = 0; i < 70000 && !tick_o; i++) begin
      prev = pin_oe_o;
      @(negedge clk_i);
    end
    chk("R8 tick seen", tick_o, 1);
    chk("R9 low at tick", pin_oe_o, 1);
    chk("R9 was high", prev, 0);
    c_fall = -1;
    c_tick = -1;
    extra  = 0;
    for (int c = 1; c <= 65536; c++) begin
      @(negedge clk_i);
      if (c == 1) chk("R8 one cycle", tick_o, 0);
      if (c == 1000) begin wr_en_i = 1'b1; wr_data_i = 8'h90; end
      if (c == 1001) wr_en_i = 1'b0;
      if (c_fall < 0 && pin_oe_o == 1'b0) c_fall = c;
      if (tick_o) begin
        if (c_tick < 0) c_tick = c;
        else extra++;
      end
    end
    chk("R7 low half", c_fall, 32768);
    chk("R8 R10 tick spacing", c_tick, 65536);
    chk("R8 single tick", extra, 0);
    chk("R9 low at 2nd tick", pin_oe_o, 1);
    chk("R10 ctrl", rd_data_o, 8'h90);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_mask();
    t_static();
    t_rates();
    t_one_hz();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 190000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule